// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Dependent Threshold Flags

This block moves words from a producer clock domain to a consumer clock domain through a parameterised memory. A mode selected while reset is held decides how the consumer sees data. In standard mode a word is delivered on `rd_data` one read-clock edge after a read request. In first-word-fall-through mode the oldest word is placed on `rd_data` without a request, and a request advances to the next word. In that mode the output register holds a word of its own, so the FIFO stores one word more than its memory depth.

Two active-low threshold flags report the fill level. `ae_n` reports that few words remain and lives in the read domain. `hf_n` reports that more than half the storage is used and lives in the write domain. Both thresholds move up by one word in fall-through mode, because the output register counts as storage. Pointers cross the domains as Gray code through a chain of synchronising flops. Each flag is therefore computed from a delayed view of the far pointer and errs on the safe side.

Top module: `xclk_fifo_flags`

## Requirements
- R1: After reset `ae_n` is 0 and `hf_n` is 1.
- R2: In standard mode (`fwft_sel` = 0 during reset), a read-clock edge that samples `rd_en` = 1 while a word is stored loads the oldest word into `rd_data` at that edge. Words leave in the order they were written.
- R3: In fall-through mode (`fwft_sel` = 1 during reset), once a stored word is visible to the read side, `rd_data` shows the oldest word without any request. An edge that samples `rd_en` = 1 removes that word and presents the next one.
- R4: Capacity is DEPTH words in standard mode and DEPTH+1 in fall-through mode. Writes beyond capacity are dropped, and no stored word is altered.
- R5: Read requests while nothing is stored are ignored. A word written afterwards is delivered intact.
- R6: In standard mode, with the count settled, `ae_n` is 0 exactly when the count is AE_OFFSET or less.
- R7: In fall-through mode, with the count settled, `ae_n` is 0 exactly when the count is AE_OFFSET+1 or less.
- R8: A write that lifts the count one word above the almost-empty limit raises `ae_n` at the third read-clock rising edge strictly after the write edge. When the two edges fall closer than the synchroniser can resolve, it may be the fourth.
- R9: A read that lowers the count to the almost-empty limit drives `ae_n` to 0 at the same read-clock edge that accepts the read.
- R10: With the count settled, `hf_n` is 0 exactly when the count exceeds DEPTH/2 in standard mode, or DEPTH/2+1 in fall-through mode.
- R11: A write that lifts the count past the half-full limit drives `hf_n` to 0 at the write-clock edge that accepts it. After reads bring the count back to the limit, `hf_n` returns to 1 within the synchroniser latency.
- R12: `fwft_sel` is sampled only while `rst_n` is low. Changing it afterwards has no effect on data delivery or on either threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains; the mode is sampled while low |
| fwft_sel | input | 1 | 1 selects fall-through mode, 0 standard mode (sampled during reset) |
| wr_en | input | 1 | Write request, sampled on the rising edge of `wclk` |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request, sampled on the rising edge of `rclk` |
| rd_data | output | WIDTH | Delivered word |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| hf_n | output | 1 | Half-full flag, active low, write domain |

## Verification
The delicate overlap is a write arriving in the write domain in the same window as a read retires a word in the read domain. The two events push the fill count in opposite directions across the almost-empty and half-full limits. The bench provokes this by forking a single-word write and a single-word read together at a fill one word above the almost-empty limit, in both modes. It judges the outcome by the settled flag levels and by the order of the words delivered. The bench also sweeps the phase between write and read edges while measuring the almost-empty release, and accepts only the third or fourth read edge.

// File: rtl/xff_pkg.sv
package xff_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } xff_mode_e;

   // words at or below this level count as almost empty
   function automatic int unsigned ae_limit(xff_mode_e m, int unsigned off);
      return (m == MODE_FWFT) ? off + 1 : off;
   endfunction

   // words above this level count as more than half full
   function automatic int unsigned hf_limit(xff_mode_e m, int unsigned depth);
      return (m == MODE_FWFT) ? depth / 2 + 1 : depth / 2;
   endfunction

   function automatic int unsigned store_cap(xff_mode_e m, int unsigned depth);
      return (m == MODE_FWFT) ? depth + 1 : depth;
   endfunction

endpackage

// File: rtl/xff_gray_sync.sv
module xff_gray_sync #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          dst_clk,
   input  logic          rst_n,
   input  logic [PW-1:0] src_gray,
   output logic [PW-1:0] dst_bin
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         initial $fatal(1, "xff_gray_sync: STAGES must be 2 or more");
      end
   endgenerate

   logic [STAGES-1:0][PW-1:0] chain;

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], src_gray};
   end

   // Gray to binary: bit i is the xor of all gray bits from i upward
   always_comb begin
      for (int i = 0; i < PW; i++) begin
         dst_bin[i] = ^(chain[STAGES-1] >> i);
      end
   end

endmodule

// File: rtl/xff_ram.sv
module xff_ram #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/xff_wr_side.sv
module xff_wr_side
   import xff_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PW    = 5
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          fwft_sel,
   input  logic          wr_en,
   input  logic [PW-1:0] rmem_bin,
   input  logic [PW-1:0] rcons_bin,
   output logic          wr_fire,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] wgray,
   output logic          hf_n
);

   xff_mode_e     mode_q;
   logic [PW-1:0] mem_seen;
   logic [PW-1:0] tot_seen;
   logic [PW-1:0] cap_lim;
   logic [PW-1:0] hf_lim;
   logic [PW-1:0] wptr_nx;
   logic [PW-1:0] tot_nx;

   always_ff @(posedge wclk) begin
      if (!rst_n) mode_q <= xff_mode_e'(fwft_sel);
   end

   always_comb begin
      cap_lim  = PW'(store_cap(mode_q, DEPTH));
      hf_lim   = PW'(hf_limit(mode_q, DEPTH));
      mem_seen = wptr - rmem_bin;
      tot_seen = wptr - rcons_bin;
      wr_fire  = wr_en && (mem_seen < PW'(DEPTH)) && (tot_seen < cap_lim);
      wptr_nx  = wptr + PW'(wr_fire);
      tot_nx   = wptr_nx - rcons_bin;
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
         hf_n  <= 1'b1;
      end else begin
         wptr  <= wptr_nx;
         wgray <= wptr_nx ^ (wptr_nx >> 1);
         hf_n  <= !(tot_nx > hf_lim);
      end
   end

endmodule

// File: rtl/xff_rd_side.sv
module xff_rd_side
   import xff_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int PW        = 5,
   parameter int AE_OFFSET = 3
) (
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             fwft_sel,
   input  logic             rd_en,
   input  logic [PW-1:0]    wsync,
   input  logic [WIDTH-1:0] rd_word,
   output logic [PW-1:0]    rmem,
   output logic [PW-1:0]    rcons,
   output logic [PW-1:0]    rmem_gray,
   output logic [PW-1:0]    rcons_gray,
   output logic [WIDTH-1:0] rd_data,
   output logic             ae_n
);

   xff_mode_e     mode_q;
   logic          ov;
   logic          ov_nx;
   logic          avail;
   logic          load;
   logic          pop;
   logic [PW-1:0] rmem_nx;
   logic [PW-1:0] rcons_nx;
   logic [PW-1:0] tot_nx;
   logic [PW-1:0] ae_lim;

   always_ff @(posedge rclk) begin
      if (!rst_n) mode_q <= xff_mode_e'(fwft_sel);
   end

   always_comb begin
      avail = (wsync != rmem);
      if (mode_q == MODE_FWFT) begin
         pop   = rd_en && ov;
         load  = avail && (!ov || pop);
         ov_nx = load || (ov && !pop);
      end else begin
         load  = rd_en && avail;
         pop   = load;
         ov_nx = 1'b0;
      end
      rmem_nx  = rmem + PW'(load);
      rcons_nx = rcons + PW'(pop);
      tot_nx   = wsync - rcons_nx;
      ae_lim   = PW'(ae_limit(mode_q, AE_OFFSET));
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rmem       <= '0;
         rcons      <= '0;
         rmem_gray  <= '0;
         rcons_gray <= '0;
         ov         <= 1'b0;
         rd_data    <= '0;
         ae_n       <= 1'b0;
      end else begin
         rmem       <= rmem_nx;
         rcons      <= rcons_nx;
         rmem_gray  <= rmem_nx ^ (rmem_nx >> 1);
         rcons_gray <= rcons_nx ^ (rcons_nx >> 1);
         ov         <= ov_nx;
         if (load) rd_data <= rd_word;
         ae_n       <= !(tot_nx <= ae_lim);
      end
   end

endmodule

// File: rtl/xclk_fifo_flags.sv
module xclk_fifo_flags #(
   parameter int WIDTH       = 8,
   parameter int DEPTH       = 16,
   parameter int AE_OFFSET   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             fwft_sel,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             ae_n,
   output logic             hf_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "xclk_fifo_flags: DEPTH must be a power of two, at least 4");
      if (AE_OFFSET < 0 || AE_OFFSET >= DEPTH)
         $fatal(1, "xclk_fifo_flags: AE_OFFSET must lie in [0, DEPTH)");
      if (WIDTH < 1)
         $fatal(1, "xclk_fifo_flags: WIDTH must be positive");
   end

   logic             wr_fire;
   logic [PW-1:0]    w_ptr;
   logic [PW-1:0]    w_gray;
   logic [PW-1:0]    w_at_r;
   logic [PW-1:0]    r_mem;
   logic [PW-1:0]    r_cons;
   logic [PW-1:0]    r_mem_gray;
   logic [PW-1:0]    r_cons_gray;
   logic [PW-1:0]    rmem_at_w;
   logic [PW-1:0]    rcons_at_w;
   logic [WIDTH-1:0] ram_q;

   xff_wr_side #(.DEPTH(DEPTH), .PW(PW)) u_wr (
      .wclk      (wclk),
      .rst_n     (rst_n),
      .fwft_sel  (fwft_sel),
      .wr_en     (wr_en),
      .rmem_bin  (rmem_at_w),
      .rcons_bin (rcons_at_w),
      .wr_fire   (wr_fire),
      .wptr      (w_ptr),
      .wgray     (w_gray),
      .hf_n      (hf_n)
   );

   xff_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .wclk  (wclk),
      .we    (wr_fire),
      .waddr (w_ptr[AW-1:0]),
      .wdata (wr_data),
      .raddr (r_mem[AW-1:0]),
      .rdata (ram_q)
   );

   xff_rd_side #(.WIDTH(WIDTH), .PW(PW), .AE_OFFSET(AE_OFFSET)) u_rd (
      .rclk       (rclk),
      .rst_n      (rst_n),
      .fwft_sel   (fwft_sel),
      .rd_en      (rd_en),
      .wsync      (w_at_r),
      .rd_word    (ram_q),
      .rmem       (r_mem),
      .rcons      (r_cons),
      .rmem_gray  (r_mem_gray),
      .rcons_gray (r_cons_gray),
      .rd_data    (rd_data),
      .ae_n       (ae_n)
   );

   xff_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .dst_clk (rclk), .rst_n (rst_n), .src_gray (w_gray), .dst_bin (w_at_r)
   );

   xff_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync_mem2w (
      .dst_clk (wclk), .rst_n (rst_n), .src_gray (r_mem_gray), .dst_bin (rmem_at_w)
   );

   xff_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync_cons2w (
      .dst_clk (wclk), .rst_n (rst_n), .src_gray (r_cons_gray), .dst_bin (rcons_at_w)
   );

endmodule

// File: rtl/xclk_fifo_flags_chk.sv
module xclk_fifo_flags_chk
   import xff_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int AE_OFFSET = 3,
   parameter int PW        = 5
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          ae_n,
   input logic          hf_n,
   input xff_mode_e     w_mode,
   input xff_mode_e     r_mode,
   input logic [PW-1:0] w_ptr,
   input logic [PW-1:0] r_mem,
   input logic [PW-1:0] r_cons
);

   logic [PW-1:0] fill;
   logic [PW-1:0] unread_mem;
   logic [PW-1:0] cap_w;
   logic [PW-1:0] hf_w;
   logic [PW-1:0] ae_r;

   always_comb begin
      fill       = w_ptr - r_cons;
      unread_mem = w_ptr - r_mem;
      cap_w      = PW'(store_cap(w_mode, DEPTH));
      hf_w       = PW'(hf_limit(w_mode, DEPTH));
      ae_r       = PW'(ae_limit(r_mode, AE_OFFSET));
   end

   // R4: the write pointer advances by at most one word per edge
   a_r4_wptr_step: assert property (@(posedge wclk) disable iff (!rst_n)
      (PW'(w_ptr - $past(w_ptr)) <= PW'(1)));

   // R4: occupancy never exceeds the mode's capacity
   a_r4_fill_cap: assert property (@(posedge wclk) disable iff (!rst_n)
      (fill <= cap_w));

   // R5: the memory read pointer never overtakes the write pointer
   a_r5_no_overread: assert property (@(posedge rclk) disable iff (!rst_n)
      (unread_mem <= PW'(DEPTH)));

   // R10: a true fill above the half-full limit is always flagged
   a_r10_hf_when_over: assert property (@(posedge wclk) disable iff (!rst_n)
      (fill > hf_w) |-> !hf_n);

   // R6 and R7: a true fill at or below the almost-empty limit is always flagged
   a_r6_ae_when_low: assert property (@(posedge rclk) disable iff (!rst_n)
      (fill <= ae_r) |-> !ae_n);

   // R12: mode held constant once out of reset
   a_r12_mode_hold_w: assert property (@(posedge wclk) disable iff (!rst_n)
      rst_n |=> $stable(w_mode));

   a_r12_mode_hold_r: assert property (@(posedge rclk) disable iff (!rst_n)
      rst_n |=> $stable(r_mode));

endmodule

bind xclk_fifo_flags xclk_fifo_flags_chk #(
   .DEPTH(DEPTH), .AE_OFFSET(AE_OFFSET), .PW(PW)
) u_chk (
   .wclk   (wclk),
   .rclk   (rclk),
   .rst_n  (rst_n),
   .ae_n   (ae_n),
   .hf_n   (hf_n),
   .w_mode (u_wr.mode_q),
   .r_mode (u_rd.mode_q),
   .w_ptr  (w_ptr),
   .r_mem  (r_mem),
   .r_cons (r_cons)
);

// File: tb/xclk_fifo_flags_tb.sv
module xclk_fifo_flags_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int W   = 8;
   localparam int D   = 16;
   localparam int OFF = 3;

   logic wclk = 1'b0;
   logic rclk = 1'b0;
   logic rst_n = 1'b0;
   logic fwft_sel = 1'b0;
   logic wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic [W-1:0] rd_data;
   logic ae_n;
   logic hf_n;

   always #4 wclk = ~wclk;      // 125 MHz
   always #5.5 rclk = ~rclk;

   xclk_fifo_flags #(.WIDTH(W), .DEPTH(D), .AE_OFFSET(OFF), .SYNC_STAGES(2)) dut_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .ae_n(ae_n), .hf_n(hf_n)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic fwft_m = 1'b0;
   logic [W-1:0] q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int cap();
      return fwft_m ? D + 1 : D;
   endfunction
   function automatic int aelim();
      return fwft_m ? OFF + 1 : OFF;
   endfunction
   function automatic int hflim();
      return fwft_m ? D / 2 + 1 : D / 2;
   endfunction
   function automatic logic exp_ae(int n);
      return !(n <= aelim());
   endfunction
   function automatic logic exp_hf(int n);
      return !(n > hflim());
   endfunction

   task automatic do_reset(input logic mode);
      rst_n = 1'b0; fwft_sel = mode; fwft_m = mode; wr_en = 0; rd_en = 0;
      q.delete();
      repeat (4) @(posedge wclk);
      repeat (4) @(posedge rclk);
      @(negedge wclk) rst_n = 1'b1;
      @(negedge rclk) chk("R1 ae_n after reset", 32'(ae_n), 32'd0);
      @(negedge wclk) chk("R1 hf_n after reset", 32'(hf_n), 32'd1);
   endtask

   task automatic wr_burst(input int n, input int prob);
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wr_en   = (($urandom % 100) < prob);
         wr_data = W'($urandom);
         if (wr_en && q.size() < cap()) q.push_back(wr_data);
      end
      @(negedge wclk) wr_en = 1'b0;
   endtask

   task automatic rd_burst(input int n, input int prob);
      logic pend = 1'b0;
      logic [W-1:0] pv = '0;
      logic r;
      for (int i = 0; i < n; i++) begin
         @(negedge rclk);
         if (pend) chk("R2 read data order", 32'(rd_data), 32'(pv));
         pend = 1'b0;
         r = (($urandom % 100) < prob);
         if (fwft_m) begin
            if (q.size() > 0) chk("R3 head word presented", 32'(rd_data), 32'(q[0]));
            if (r && q.size() > 0) void'(q.pop_front());
         end else if (r && q.size() > 0) begin
            pend = 1'b1;
            pv   = q.pop_front();
         end
         rd_en = r;
      end
      @(negedge rclk);
      rd_en = 1'b0;
      if (pend) chk("R2 read data order", 32'(rd_data), 32'(pv));
   endtask

   task automatic settle_chk();
      repeat (8) @(posedge rclk);
      repeat (8) @(posedge wclk);
      @(negedge rclk);
      chk(fwft_m ? "R7 ae_n level" : "R6 ae_n level", 32'(ae_n), 32'(exp_ae(q.size())));
      if (fwft_m && q.size() > 0) chk("R3 head without request", 32'(rd_data), 32'(q[0]));
      @(negedge wclk);
      chk("R10 hf_n level", 32'(hf_n), 32'(exp_hf(q.size())));
   endtask

   task automatic drain();
      rd_burst(q.size() + 1, 100);
      settle_chk();
   endtask

   // R8 release latency and R9 reassertion, q.size() == aelim() on entry
   task automatic ae_edge_tests(input int rounds);
      for (int k = 0; k < rounds; k++) begin
         realtime tw;
         int e;
         int hit;
         repeat (k) @(posedge rclk);
         @(negedge wclk);
         wr_en = 1'b1; wr_data = W'($urandom); q.push_back(wr_data);
         @(posedge wclk);
         tw = $realtime;
         fork
            begin @(negedge wclk) wr_en = 1'b0; end
         join_none
         e = 0; hit = 0;
         for (int s = 0; s < 10 && hit == 0; s++) begin
            @(posedge rclk);
            if ($realtime > tw) begin
               e++;
               @(negedge rclk);
               if (ae_n === 1'b1) hit = e;
            end
         end
         chk("R8 ae_n release edge", 32'(hit), (hit == 4) ? 32'd4 : 32'd3);
         repeat (6) @(posedge wclk);
         repeat (2) @(posedge rclk);
         rd_burst(1, 100);
         chk("R9 ae_n on read edge", 32'(ae_n), 32'd0);
         settle_chk();
      end
   endtask

   task automatic hf_edge_test();
      // q.size() == hflim() on entry
      @(negedge wclk);
      wr_en = 1'b1; wr_data = W'($urandom); q.push_back(wr_data);
      @(negedge wclk);
      wr_en = 1'b0;
      chk("R11 hf_n on write edge", 32'(hf_n), 32'd0);
      rd_burst(1, 100);
      repeat (8) @(posedge wclk);
      @(negedge wclk);
      chk("R11 hf_n release", 32'(hf_n), 32'd1);
   endtask

   task automatic concurrent_test();
      // write and read issued together one word above the almost-empty limit
      fork
         wr_burst(1, 100);
         rd_burst(1, 100);
      join
      settle_chk();
      chk("R6 fill unchanged by overlap", 32'(q.size()), 32'(aelim() + 1));
   endtask

   task automatic random_rounds(input int n);
      for (int r = 0; r < n; r++) begin
         wr_burst(int'($urandom % (D + 4)), 70);
         settle_chk();
         rd_burst(int'($urandom % (D + 4)), 60);
         settle_chk();
      end
   endtask

   task automatic run_mode(input logic mode);
      int base;
      do_reset(mode);
      if (!mode) fwft_sel = 1'b1;      // R12: toggle after reset
      // threshold sweep, one word at a time
      for (int k = 1; k <= D / 2 + 3; k++) begin
         wr_burst(1, 100);
         settle_chk();
         if (!mode && k == OFF + 1) chk("R12 mode change ignored", 32'(ae_n), 32'd1);
      end
      rd_burst(q.size() - hflim(), 100);
      settle_chk();
      hf_edge_test();
      settle_chk();
      // empty reads, then one word (R5)
      rd_burst(q.size() + 4, 100);
      settle_chk();
      wr_burst(1, 100);
      settle_chk();
      base = q.size();
      chk("R5 word after empty reads", 32'(base), 32'd1);
      drain();
      // R8/R9
      wr_burst(aelim(), 100);
      settle_chk();
      ae_edge_tests(4);
      wr_burst(1, 100);
      settle_chk();
      concurrent_test();
      drain();
      // R4 overflow
      wr_burst(D + 4, 100);
      settle_chk();
      chk("R4 stored word count", 32'(q.size()), 32'(cap()));
      chk("R4 hf_n at capacity", 32'(hf_n), 32'd0);
      drain();
      random_rounds(10);
      drain();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      run_mode(1'b0);
      run_mode(1'b1);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule